// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Line

This block gathers level-sensitive interrupt lines from peripherals and turns them into one vector number for the processor core. Each line is first passed through a synchroniser. Lines in the normal range land in a raw pending register. Software gates that register with a mask. The gated result is encoded onto a registered 8-bit vector bus. No gated line gives vector 0. A single gated line gives a vector unique to that line. Two or more gated lines give one shared vector. In the shared case software reads the gated register and decides the order of service itself.

The top lines of the input range bypass the mask and the vector entirely. They feed a non-maskable status register, and an output line is high whenever any bit of that register is set.

A 32-bit register port handles software access. Through it software writes the mask and reads the mask, the raw pending bits, the gated pending bits, the non-maskable status and a debug word.

The encoder is a small state machine with three states:
- `VEC_QUIET`: nothing gated.
- `VEC_SINGLE`: exactly one gated line.
- `VEC_SHARED`: more than one gated line.

Every cycle the next state is chosen from the gated bits. Any state can move to any other state, and it does so in the cycle after the gated bits change. A zero pattern leads to `VEC_QUIET`, a one-hot pattern to `VEC_SINGLE`, and anything else to `VEC_SHARED`. The vector bus is registered along with the state.

Top module: `vic_top`

## Requirements
- R1: After reset the vector bus, the non-maskable output and every readable word are zero.
- R2: Reads by word offset return the following:
  - Offset 0: the mask, all 32 bits, read/write.
  - Offset 1: the raw pending bits.
  - Offset 2: the raw pending bits AND the mask.
  - Offset 3: the non-maskable status.
  - Offset 4: the debug word, which is always zero.
  - Offsets 5 to 7: zero.
- R3: When no gated bit is set, the vector bus is 0x00.
- R4: When exactly one gated bit k is set, the vector bus is 0x31 + k.
- R5: When two or more gated bits are set, the vector bus is 0x30.
- R6: Input line n, for n from 1 to 29, drives raw pending bit n-1 high or low following its level.
- R7: Input lines 30 and 31 drive non-maskable status bits 30 and 31.
  - These lines never appear in the raw pending word.
  - They are not affected by the mask.
  - The non-maskable output is the OR of the status bits.
- R8: A write to any offset other than 0 leaves the mask unchanged.
- R9: A write whose four byte enables are not all set leaves the mask unchanged.
- R10: Latency is fixed:
  - An input change appears in the raw pending word after two rising edges.
  - The vector bus follows one edge after a change of the raw pending word or of the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line | input | 31 | Interrupt lines, indexed 31 down to 1 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_be | input | 4 | Byte enables; a write takes effect only when all are set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_vec | output | 8 | Registered vector bus |
| nmi_out | output | 1 | Non-maskable interrupt request |

## Verification
The encoder is exercised with several input patterns, and each one distinguishes a different fault:
- Every single normal line with the mask fully open. This proves each line maps to its own pending bit and its own vector, so an off-by-one in routing or in the vector base is exposed.
- Every pair of normal lines. Any pair that leaks through as a single-line vector shows the multiple-set detection is wrong.
- A one-hot sweep of the mask with every line raised. This separates gating faults from routing faults.
- Mixed mask and line words, checked against the AND read back at offset 2.

Further tests cover the non-maskable lines, write attempts that must be ignored, and the exact edge on which each output moves.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        VEC_QUIET  = 2'd0,
        VEC_SINGLE = 2'd1,
        VEC_SHARED = 2'd2
    } vec_state_e;

    localparam logic [2:0] OFS_MASK   = 3'd0;
    localparam logic [2:0] OFS_RAW    = 3'd1;
    localparam logic [2:0] OFS_MASKED = 3'd2;
    localparam logic [2:0] OFS_NMI    = 3'd3;
    localparam logic [2:0] OFS_DEBUG  = 3'd4;

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W      = 31,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NORM_W = 29,
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   raw_pend,
    input  logic [DATA_W-1:0]   nmi_stat,
    output logic [NORM_W-1:0]   gated_norm,
    output logic [DATA_W-1:0]   bus_rdata
);

    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] gated;
    logic              mask_we;

    assign mask_we = bus_sel && bus_wr && (bus_addr == OFS_MASK)
                     && (bus_be == {BE_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= bus_wdata;
    end

    assign gated      = raw_pend & mask_q;
    assign gated_norm = gated[NORM_W-1:0];

    always_comb begin
        unique case (bus_addr)
            OFS_MASK:   bus_rdata = mask_q;
            OFS_RAW:    bus_rdata = raw_pend;
            OFS_MASKED: bus_rdata = gated;
            OFS_NMI:    bus_rdata = nmi_stat;
            OFS_DEBUG:  bus_rdata = '0;
            default:    bus_rdata = '0;
        endcase
    end

    // R2
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == OFS_MASK && bus_be == {BE_W{1'b1}})
        |=> (mask_q == $past(bus_wdata)));

    // R8
    ro_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != OFS_MASK) |=> $stable(mask_q));

    // R9
    partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be != {BE_W{1'b1}}) |=> $stable(mask_q));

endmodule

// File: rtl/vic_vector.sv
module vic_vector
    import vic_pkg::*;
#(
    parameter int           N           = 29,
    parameter int           VEC_W       = 8,
    parameter logic [7:0]   SHARED_CODE = 8'h30,
    parameter logic [7:0]   BASE_CODE   = 8'h31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pend_in,
    output logic [VEC_W-1:0] vec_out
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    vec_state_e       state_q, state_nxt;
    logic [IDX_W-1:0] low_idx;
    logic             low_found;
    logic             many;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        low_idx   = '0;
        low_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pend_in[i] && !low_found) begin
                low_idx   = IDX_W'(i);
                low_found = 1'b1;
            end
        end
    end

    assign many = |(pend_in & (pend_in - N'(1)));

    always_comb begin
        if (pend_in == '0) state_nxt = VEC_QUIET;
        else if (many)     state_nxt = VEC_SHARED;
        else               state_nxt = VEC_SINGLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= VEC_QUIET;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else begin
            unique case (state_nxt)
                VEC_QUIET:  vec_q <= '0;
                VEC_SINGLE: vec_q <= VEC_W'(BASE_CODE) + VEC_W'(low_idx);
                VEC_SHARED: vec_q <= VEC_W'(SHARED_CODE);
                default:    vec_q <= '0;
            endcase
        end
    end

    assign vec_out = vec_q;

    // R3
    vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_in == '0) |=> (vec_out == '0));

    // R5
    vec_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pend_in) > 1) |=> (vec_out == VEC_W'(SHARED_CODE)));

    // R4
    vec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(pend_in) |=> (vec_out >= VEC_W'(BASE_CODE)
                              && vec_out < VEC_W'(BASE_CODE) + VEC_W'(N)));

    // R4
    state_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == VEC_SINGLE) |-> (vec_out != '0 && vec_out != VEC_W'(SHARED_CODE)));

endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int NUM_IN      = 32,
    parameter int NMI_BASE    = 30,
    parameter int DATA_W      = 32,
    parameter int VEC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:1]   irq_line,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [VEC_W-1:0]    irq_vec,
    output logic                nmi_out
);

    localparam int NORM_W = NMI_BASE - 1;
    localparam int LINE_W = NUM_IN - 1;

    logic [LINE_W-1:0] sync_q;
    logic [DATA_W-1:0] raw_pend;
    logic [DATA_W-1:0] nmi_stat;
    logic [NORM_W-1:0] gated_norm;

    vic_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_line),
        .q     (sync_q)
    );

    // line n (sync_q[n-1]) -> raw bit n-1 for normal lines
    assign raw_pend = DATA_W'(sync_q[NORM_W-1:0]);
    // lines NMI_BASE.. keep their own bit position
    assign nmi_stat = {sync_q[LINE_W-1:NORM_W], {NMI_BASE{1'b0}}};
    assign nmi_out  = |nmi_stat;

    vic_regs #(.DATA_W(DATA_W), .NORM_W(NORM_W), .ADDR_W(3)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_be     (bus_be),
        .bus_wdata  (bus_wdata),
        .raw_pend   (raw_pend),
        .nmi_stat   (nmi_stat),
        .gated_norm (gated_norm),
        .bus_rdata  (bus_rdata)
    );

    vic_vector #(.N(NORM_W), .VEC_W(VEC_W)) u_vector (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_in (gated_norm),
        .vec_out (irq_vec)
    );

    // R7
    nmi_vec_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_q[NORM_W-1:0] == '0) |=> (irq_vec == '0));

endmodule

// File: tb/test_vic_top.sv
module test_vic_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:1] irq_line = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_vec;
    logic        nmi_out;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    vic_top i_vic_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_line  (irq_line),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_vec   (irq_vec),
        .nmi_out   (nmi_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_sel  = 1'b1;
        bus_wr   = 1'b0;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_addr  = a;
        bus_wdata = d;
        bus_be    = be;
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    function automatic logic [31:0] exp_raw(input logic [31:1] l);
        logic [31:0] r = '0;
        for (int n = 1; n <= 29; n++) r[n-1] = l[n];
        return r;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [31:0] g);
        int cnt = 0;
        int pos = 0;
        for (int k = 0; k < 29; k++) begin
            if (g[k]) begin
                if (cnt == 0) pos = k;
                cnt++;
            end
        end
        if (cnt == 0) return 8'h00;
        if (cnt > 1)  return 8'h30;
        return 8'(8'h31 + pos);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] m;
        logic [31:1] l;

        // R1 reset state
        step(3);
        check("R1 vec", {24'h0, irq_vec}, 32'h0);
        check("R1 nmi", {31'h0, nmi_out}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 word", d, 32'h0);
        end
        rst_n = 1'b1;
        step(1);

        // R2 mask holds all 32 bits
        wr(3'd0, 32'hFFFF_FFFF, 4'hF);
        rd(3'd0, d);
        check("R2 mask rw", d, 32'hFFFF_FFFF);
        step(1);
        check("R3 idle vec", {24'h0, irq_vec}, 32'h0);

        // R4/R6 every single normal line
        for (int n = 1; n <= 29; n++) begin
            irq_line = '0;
            irq_line[n] = 1'b1;
            step(4);
            check("R4 single vec", {24'h0, irq_vec}, 32'(8'h31 + n - 1));
            rd(3'd1, d);
            check("R6 raw bit", d, 32'h1 << (n - 1));
            rd(3'd2, d);
            check("R2 gated", d, 32'h1 << (n - 1));
        end

        // R5 every pair of normal lines
        for (int i = 1; i <= 29; i++) begin
            for (int j = i + 1; j <= 29; j++) begin
                irq_line = '0;
                irq_line[i] = 1'b1;
                irq_line[j] = 1'b1;
                step(4);
                check("R5 pair vec", {24'h0, irq_vec}, 32'h30);
            end
        end

        // R3/R4 one-hot mask over all raised lines
        irq_line = '0;
        for (int n = 1; n <= 29; n++) irq_line[n] = 1'b1;
        step(3);
        for (int k = 0; k < 29; k++) begin
            wr(3'd0, 32'h1 << k, 4'hF);
            step(1);
            check("R4 mask onehot vec", {24'h0, irq_vec}, 32'(8'h31 + k));
            rd(3'd2, d);
            check("R2 gated onehot", d, 32'h1 << k);
        end
        wr(3'd0, 32'h0, 4'hF);
        step(1);
        check("R3 mask zero vec", {24'h0, irq_vec}, 32'h0);

        // R2 mixed patterns
        for (int p = 0; p < 6; p++) begin
            m = 32'h00F0_F0F0 ^ (32'h1357_9BDF * p);
            l = 31'(32'h2468_ACE1 * (p + 3));
            irq_line = l;
            wr(3'd0, m, 4'hF);
            step(4);
            rd(3'd2, d);
            check("R2 gated mix", d, exp_raw(l) & m);
            check("R2 vec mix", {24'h0, irq_vec}, {24'h0, exp_vec(exp_raw(l) & m)});
        end

        // R10 latency
        wr(3'd0, 32'hFFFF_FFFF, 4'hF);
        irq_line = '0;
        step(4);
        irq_line[5] = 1'b1;
        step(1);
        rd(3'd1, d);
        check("R10 raw after 1 edge", d, 32'h0);
        step(1);
        rd(3'd1, d);
        check("R10 raw after 2 edges", d, 32'h10);
        check("R10 vec lags raw", {24'h0, irq_vec}, 32'h0);
        step(1);
        check("R10 vec after 3 edges", {24'h0, irq_vec}, 32'h35);
        wr(3'd0, 32'h0, 4'hF);
        check("R10 vec lags mask", {24'h0, irq_vec}, 32'h35);
        step(1);
        check("R10 vec after mask", {24'h0, irq_vec}, 32'h0);

        // R7 non-maskable lines
        irq_line = '0;
        irq_line[30] = 1'b1;
        step(4);
        check("R7 nmi out", {31'h0, nmi_out}, 32'h1);
        rd(3'd3, d);
        check("R7 nmi word 30", d, 32'h4000_0000);
        rd(3'd1, d);
        check("R7 raw untouched", d, 32'h0);
        check("R7 vec untouched", {24'h0, irq_vec}, 32'h0);
        irq_line[31] = 1'b1;
        step(4);
        rd(3'd3, d);
        check("R7 nmi word both", d, 32'hC000_0000);
        irq_line[30] = 1'b0;
        step(4);
        rd(3'd3, d);
        check("R7 nmi word 31", d, 32'h8000_0000);
        check("R7 nmi out 31", {31'h0, nmi_out}, 32'h1);
        wr(3'd0, 32'hFFFF_FFFF, 4'hF);
        irq_line[3] = 1'b1;
        step(4);
        check("R7 vec ignores nmi", {24'h0, irq_vec}, 32'h33);
        irq_line = '0;
        step(4);
        check("R7 nmi cleared", {31'h0, nmi_out}, 32'h0);

        // R8 writes elsewhere ignored
        wr(3'd0, 32'h0000_0004, 4'hF);
        irq_line[3] = 1'b1;
        step(4);
        for (int a = 1; a < 8; a++) begin
            wr(3'(a), 32'h1234_5678, 4'hF);
            step(1);
            rd(3'd0, d);
            check("R8 mask kept", d, 32'h4);
            check("R8 vec kept", {24'h0, irq_vec}, 32'h33);
        end
        rd(3'd4, d);
        check("R2 debug zero", d, 32'h0);

        // R9 partial writes ignored
        for (int b = 0; b < 15; b++) begin
            wr(3'd0, 32'hFFFF_FFFF, 4'(b));
            step(1);
            rd(3'd0, d);
            check("R9 mask kept", d, 32'h4);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule